// File: doc/BRIEF.md
# Speculative Load Address Check Table

This block keeps track of loads that a compiler has moved ahead of earlier stores. When such a load issues, it records its destination register number together with the memory word it read. Every store that executes afterwards is compared, in one cycle, against every recorded word. A store to a recorded word invalidates that record, because the hoisted load may have read stale data.

Later, a check operation names a destination register and asks whether that load is still safe. The answer is pass only if a valid record for that register is present. A record that was invalidated and a record that never existed give the same answer: fail. On a fail, the pipeline branches to recovery code. A check may optionally remove its record once it has been looked up.

The table compares addresses at 8-byte word granularity. When it is full, it makes room by replacing records in a rotating order.

Top module: `specld_table`

## Requirements
- R1: After reset every record is invalid, `chk_rsp_vld` and `chk_pass` are 0, and a check of any tag fails.
- R2: The response to a check appears on `chk_rsp_vld`/`chk_pass` exactly one clock cycle after `chk_vld` is high, and lasts one cycle. A check of a tag that has a valid record passes (`chk_pass`=1).
- R3: A check of a tag that has never been recorded since reset fails. `chk_pass` is never 1 while `chk_rsp_vld` is 0.
- R4: A store invalidates every valid record whose word address (address bits above bit 2) equals the store's word address. A store to any other word leaves the record valid.
- R5: A check with `chk_clr`=0 leaves its record valid. A check with `chk_clr`=1 removes the record, so the next check of that tag fails.
- R6: Recording a tag that already has a valid record overwrites that record. Afterwards only the new address is snooped, and there is never more than one valid record per tag.
- R7: Recording a new tag takes the lowest-numbered free record. Sixteen distinct tags can be held at once, and all of them pass.
- R8: When all records are valid and the tag is new, the record at a rotating pointer is replaced. The pointer starts at record 0 after reset and advances by one (wrapping after 15) only on such a replacement.
- R9: When a store and a recording happen in the same cycle, the recording is younger. The new record is valid even if its word matches the store, while other records on that word are invalidated. The same holds for a clearing check on the recorded tag in the same cycle.
- R10: A check sees the table as it was before the same cycle's store, recording or clear. For example, a check in the same cycle as an invalidating store still passes, and a check in the same cycle as the first recording of its tag fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_vld | input | 1 | Record a speculative load this cycle |
| alloc_tag | input | TAG_W | Destination register number of the load |
| alloc_addr | input | ADDR_W | Byte address read by the load |
| st_vld | input | 1 | A store executes this cycle |
| st_addr | input | ADDR_W | Byte address of the store |
| chk_vld | input | 1 | Check request this cycle |
| chk_tag | input | TAG_W | Register number to check |
| chk_clr | input | 1 | Remove the checked record after lookup |
| chk_rsp_vld | output | 1 | Check response valid (one cycle after the request) |
| chk_pass | output | 1 | 1 = record valid, 0 = recovery code required |

## Verification
The bench keeps the default 16 records and 7-bit tags, which allows it to fill the whole table and walk the replacement pointer around completely. It narrows ADDR_W to 16. In the long sweep it also draws addresses from only eight words and tags from only 24 values. This makes store hits, repeated tags, same-cycle conflicts and evictions frequent. A reference table computed in the bench from the requirements predicts every response.

// File: rtl/specld_pkg.sv
package specld_pkg;

  localparam int unsigned SPECLD_ENTRIES    = 16;
  localparam int unsigned SPECLD_TAG_W      = 7;
  localparam int unsigned SPECLD_ADDR_W     = 48;
  localparam int unsigned SPECLD_WORD_SHIFT = 3;

  typedef enum logic [1:0] {
    VSRC_NONE = 2'd0,
    VSRC_HIT  = 2'd1,
    VSRC_FREE = 2'd2,
    VSRC_ROT  = 2'd3
  } vsrc_e;

endpackage

// File: rtl/specld_entry.sv
module specld_entry #(
  parameter int unsigned TAG_W  = 7,
  parameter int unsigned WORD_W = 45
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              st_vld,
  input  logic [WORD_W-1:0] st_word,
  input  logic              clr,
  input  logic [TAG_W-1:0]  chk_tag,
  output logic              vld,
  output logic              alloc_hit,
  output logic              chk_hit
);

  logic              vld_q, vld_d;
  logic [TAG_W-1:0]  tag_q, tag_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              st_hit;

  assign st_hit    = st_vld && vld_q && (word_q == st_word);
  assign alloc_hit = vld_q && (tag_q == wr_tag);
  assign chk_hit   = vld_q && (tag_q == chk_tag);
  assign vld       = vld_q;

  always_comb begin
    vld_d  = vld_q;
    tag_d  = tag_q;
    word_d = word_q;
    if (wr_en) begin
      vld_d  = 1'b1;
      tag_d  = wr_tag;
      word_d = wr_word;
    end else if (st_hit || clr) begin
      vld_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q  <= '0;
      word_q <= '0;
    end else if (wr_en) begin
      tag_q  <= tag_d;
      word_q <= word_d;
    end
  end

  // R4: a matching store with no same-cycle write drops the record
  a_r4_store_kills: assert property (@(posedge clk) disable iff (!rst_n)
    (st_hit && !wr_en) |=> !vld_q);

  // R9: a write always leaves a valid record holding the written tag
  a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (vld_q && tag_q == $past(wr_tag)));

  // R5: with no write, store hit or clear, a valid record stays valid
  a_r5_record_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !wr_en && !st_hit && !clr) |=> vld_q);

endmodule

// File: rtl/specld_victim.sv
module specld_victim
  import specld_pkg::*;
#(
  parameter int unsigned ENTRIES = 16,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_vld,
  input  logic [ENTRIES-1:0] hit_vec,
  input  logic [ENTRIES-1:0] vld_vec,
  output logic [ENTRIES-1:0] wr_vec
);

  logic [IDX_W-1:0]   rot_q, rot_d;
  logic [ENTRIES-1:0] free_vec;
  logic [ENTRIES-1:0] rot_vec;
  logic               free_found;
  logic               rot_en;
  vsrc_e              src;

  always_comb begin
    free_vec   = '0;
    free_found = 1'b0;
    for (int i = 0; i < int'(ENTRIES); i++) begin
      if (!vld_vec[i] && !free_found) begin
        free_vec[i] = 1'b1;
        free_found  = 1'b1;
      end
    end
  end

  always_comb begin
    rot_vec        = '0;
    rot_vec[rot_q] = 1'b1;
  end

  always_comb begin
    if (!alloc_vld)     src = VSRC_NONE;
    else if (|hit_vec)  src = VSRC_HIT;
    else if (free_found) src = VSRC_FREE;
    else                src = VSRC_ROT;
  end

  always_comb begin
    unique case (src)
      VSRC_HIT:  wr_vec = hit_vec;
      VSRC_FREE: wr_vec = free_vec;
      VSRC_ROT:  wr_vec = rot_vec;
      default:   wr_vec = '0;
    endcase
  end

  assign rot_en = (src == VSRC_ROT);

  always_comb begin
    if (rot_q == IDX_W'(ENTRIES - 1)) rot_d = '0;
    else                              rot_d = rot_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rot_q <= '0;
    end else if (rot_en) begin
      rot_q <= rot_d;
    end
  end

  // R7: every recording selects exactly one record
  a_r7_one_victim: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_vld |-> $onehot(wr_vec));

  // R7: with a free record and no tag hit, the chosen record was free
  a_r7_free_first: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_vld && !(|hit_vec) && !(&vld_vec)) |-> ((wr_vec & vld_vec) == '0));

  // R8: a replacement in a full table moves the pointer
  a_r8_rot_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_vld && !(|hit_vec) && (&vld_vec)) |=> (rot_q != $past(rot_q)));

  // R8: without a replacement the pointer keeps its value
  a_r8_rot_still: assert property (@(posedge clk) disable iff (!rst_n)
    !(alloc_vld && !(|hit_vec) && (&vld_vec)) |=> $stable(rot_q));

endmodule

// File: rtl/specld_table.sv
module specld_table
  import specld_pkg::*;
#(
  parameter int unsigned ENTRIES    = SPECLD_ENTRIES,
  parameter int unsigned TAG_W      = SPECLD_TAG_W,
  parameter int unsigned ADDR_W     = SPECLD_ADDR_W,
  parameter int unsigned WORD_SHIFT = SPECLD_WORD_SHIFT,
  localparam int unsigned WORD_W    = ADDR_W - WORD_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_vld,
  input  logic [TAG_W-1:0]  alloc_tag,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic              st_vld,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic              chk_vld,
  input  logic [TAG_W-1:0]  chk_tag,
  input  logic              chk_clr,
  output logic              chk_rsp_vld,
  output logic              chk_pass
);

  logic [WORD_W-1:0]  alloc_word;
  logic [WORD_W-1:0]  st_word;
  logic [ENTRIES-1:0] vld_vec;
  logic [ENTRIES-1:0] alloc_hit_vec;
  logic [ENTRIES-1:0] chk_hit_vec;
  logic [ENTRIES-1:0] wr_vec;
  logic [ENTRIES-1:0] clr_vec;
  logic               rsp_vld_q, rsp_vld_d;
  logic               pass_q, pass_d;
  logic               unused_lo_bits;

  assign alloc_word     = alloc_addr[ADDR_W-1:WORD_SHIFT];
  assign st_word        = st_addr[ADDR_W-1:WORD_SHIFT];
  assign unused_lo_bits = ^{alloc_addr[WORD_SHIFT-1:0], st_addr[WORD_SHIFT-1:0]};

  assign clr_vec = (chk_vld && chk_clr) ? chk_hit_vec : '0;

  for (genvar g = 0; g < int'(ENTRIES); g++) begin : g_rec
    specld_entry #(
      .TAG_W  (TAG_W),
      .WORD_W (WORD_W)
    ) u_rec (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_vec[g]),
      .wr_tag    (alloc_tag),
      .wr_word   (alloc_word),
      .st_vld    (st_vld),
      .st_word   (st_word),
      .clr       (clr_vec[g]),
      .chk_tag   (chk_tag),
      .vld       (vld_vec[g]),
      .alloc_hit (alloc_hit_vec[g]),
      .chk_hit   (chk_hit_vec[g])
    );
  end

  specld_victim #(
    .ENTRIES (ENTRIES)
  ) u_victim (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_vld (alloc_vld),
    .hit_vec   (alloc_hit_vec),
    .vld_vec   (vld_vec),
    .wr_vec    (wr_vec)
  );

  always_comb begin
    rsp_vld_d = chk_vld;
    pass_d    = chk_vld && (|chk_hit_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_vld_q <= 1'b0;
      pass_q    <= 1'b0;
    end else begin
      rsp_vld_q <= rsp_vld_d;
      pass_q    <= pass_d;
    end
  end

  assign chk_rsp_vld = rsp_vld_q;
  assign chk_pass    = pass_q;

  // R6: at most one valid record per tag, seen from both lookups
  a_r6_one_per_tag: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(alloc_hit_vec) && $onehot0(chk_hit_vec));

  // R2: a request is answered in the following cycle
  a_r2_rsp_timing: assert property (@(posedge clk) disable iff (!rst_n)
    chk_vld |=> chk_rsp_vld);

  // R3: no pass outside a response
  a_r3_pass_needs_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_rsp_vld |-> !chk_pass);

  // R10: a check against an empty table cannot pass
  a_r10_empty_fails: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_vld && vld_vec == '0) |=> !chk_pass);

endmodule

// File: tb/sim_specld_table.sv
`timescale 1ns/1ps
module sim_specld_table;

  localparam int unsigned N   = 16;
  localparam int unsigned TW  = 7;
  localparam int unsigned AW  = 16;

  logic          clk;
  logic          rst_n;
  logic          alloc_vld;
  logic [TW-1:0] alloc_tag;
  logic [AW-1:0] alloc_addr;
  logic          st_vld;
  logic [AW-1:0] st_addr;
  logic          chk_vld;
  logic [TW-1:0] chk_tag;
  logic          chk_clr;
  logic          chk_rsp_vld;
  logic          chk_pass;

  int checks;
  int failures;
  int cyc;
  bit done;

  logic          m_vld  [N];
  logic [TW-1:0] m_tag  [N];
  logic [AW-4:0] m_word [N];
  int            m_rot;
  logic          m_exp;

  specld_table #(
    .ENTRIES    (N),
    .TAG_W      (TW),
    .ADDR_W     (AW),
    .WORD_SHIFT (3)
  ) u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_vld   (alloc_vld),
    .alloc_tag   (alloc_tag),
    .alloc_addr  (alloc_addr),
    .st_vld      (st_vld),
    .st_addr     (st_addr),
    .chk_vld     (chk_vld),
    .chk_tag     (chk_tag),
    .chk_clr     (chk_clr),
    .chk_rsp_vld (chk_rsp_vld),
    .chk_pass    (chk_pass)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 200000 && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 200000)", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    alloc_vld = 0; alloc_tag = '0; alloc_addr = '0;
    st_vld = 0; st_addr = '0;
    chk_vld = 0; chk_tag = '0; chk_clr = 0;
    rst_n = 0;
    for (int i = 0; i < int'(N); i++) m_vld[i] = 1'b0;
    m_rot = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  // Drive one cycle at a falling edge; on return the response to it is visible.
  task automatic step(input logic av, input logic [TW-1:0] at, input logic [AW-1:0] aa,
                      input logic sv, input logic [AW-1:0] sa,
                      input logic cv, input logic [TW-1:0] ct, input logic cc);
    int hit;
    int tgt;
    alloc_vld = av; alloc_tag = at; alloc_addr = aa;
    st_vld = sv; st_addr = sa;
    chk_vld = cv; chk_tag = ct; chk_clr = cc;
    hit = -1;
    for (int i = 0; i < int'(N); i++) if (m_vld[i] && m_tag[i] == ct) hit = i;
    m_exp = cv && (hit >= 0);
    tgt = -1;
    if (av) begin
      for (int i = 0; i < int'(N); i++) if (m_vld[i] && m_tag[i] == at) tgt = i;
      if (tgt < 0) for (int i = int'(N) - 1; i >= 0; i--) if (!m_vld[i]) tgt = i;
      if (tgt < 0) begin
        tgt = m_rot;
        m_rot = (m_rot + 1) % int'(N);
      end
    end
    if (sv) for (int i = 0; i < int'(N); i++)
      if (m_vld[i] && m_word[i] == sa[AW-1:3] && i != tgt) m_vld[i] = 1'b0;
    if (cv && cc && hit >= 0 && hit != tgt) m_vld[hit] = 1'b0;
    if (tgt >= 0) begin
      m_vld[tgt] = 1'b1; m_tag[tgt] = at; m_word[tgt] = aa[AW-1:3];
    end
    @(negedge clk);
    alloc_vld = 0; st_vld = 0; chk_vld = 0; chk_clr = 0;
  endtask

  task automatic alloc(input logic [TW-1:0] t, input logic [AW-1:0] a);
    step(1, t, a, 0, '0, 0, '0, 0);
  endtask

  task automatic store(input logic [AW-1:0] a);
    step(0, '0, '0, 1, a, 0, '0, 0);
  endtask

  task automatic probe(input string req, input logic [TW-1:0] t, input logic cc, input logic exp);
    step(0, '0, '0, 0, '0, 1, t, cc);
    chk(req, chk_rsp_vld, 1'b1);
    chk(req, chk_pass, exp);
  endtask

  initial begin
    checks = 0; failures = 0; cyc = 0; done = 0;
    do_reset();

    // R1: reset state
    chk("R1 rsp_vld after reset", chk_rsp_vld, 1'b0);
    chk("R1 pass after reset", chk_pass, 1'b0);
    probe("R1 check after reset", 7'd5, 0, 1'b0);
    // R2: response lasts one cycle only
    @(negedge clk);
    chk("R2 rsp drops", chk_rsp_vld, 1'b0);

    // R2 / R3
    probe("R3 unknown tag", 7'd99, 0, 1'b0);
    alloc(7'd5, 16'h0100);
    probe("R2 recorded tag passes", 7'd5, 0, 1'b1);

    // R4: same word (offset 4) kills, other word does not
    store(16'h0104);
    probe("R4 same-word store", 7'd5, 0, 1'b0);
    alloc(7'd6, 16'h0200);
    store(16'h0208);
    probe("R4 other-word store", 7'd6, 0, 1'b1);
    alloc(7'd11, 16'h0700);
    alloc(7'd12, 16'h0703);
    store(16'h0707);
    probe("R4 multi-kill a", 7'd11, 0, 1'b0);
    probe("R4 multi-kill b", 7'd12, 0, 1'b0);

    // R5: keep versus clear
    probe("R5 keep 1", 7'd6, 0, 1'b1);
    probe("R5 keep 2", 7'd6, 1, 1'b1);
    probe("R5 cleared", 7'd6, 0, 1'b0);

    // R6: overwrite same tag
    alloc(7'd7, 16'h0300);
    alloc(7'd7, 16'h0400);
    store(16'h0300);
    probe("R6 old addr ignored", 7'd7, 0, 1'b1);
    store(16'h0400);
    probe("R6 new addr snooped", 7'd7, 0, 1'b0);

    // R9: same-cycle store and recording
    alloc(7'd9, 16'h0500);
    step(1, 7'd8, 16'h0500, 1, 16'h0502, 0, '0, 0);
    probe("R9 new record valid", 7'd8, 0, 1'b1);
    probe("R9 older record killed", 7'd9, 0, 1'b0);
    step(1, 7'd8, 16'h0580, 0, '0, 1, 7'd8, 1);
    probe("R9 record beats clear", 7'd8, 0, 1'b1);

    // R10: check sees state before the cycle's updates
    alloc(7'd10, 16'h0600);
    step(0, '0, '0, 1, 16'h0600, 1, 7'd10, 0);
    chk("R10 check vs store", chk_pass, 1'b1);
    probe("R10 then killed", 7'd10, 0, 1'b0);
    step(1, 7'd13, 16'h0800, 0, '0, 1, 7'd13, 0);
    chk("R10 check vs first record", chk_pass, 1'b0);
    probe("R10 then present", 7'd13, 0, 1'b1);

    // R7 / R8: fill and rotate
    do_reset();
    for (int k = 0; k < int'(N); k++) alloc(TW'(20 + k), AW'(16'h1000 + 8 * k));
    for (int k = 0; k < int'(N); k++) probe("R7 full table holds", TW'(20 + k), 0, 1'b1);
    alloc(7'd40, 16'h2000);
    probe("R8 record 0 replaced", 7'd20, 0, 1'b0);
    probe("R8 record 1 kept", 7'd21, 0, 1'b1);
    probe("R8 new tag present", 7'd40, 0, 1'b1);
    alloc(7'd41, 16'h2008);
    probe("R8 record 1 replaced", 7'd21, 0, 1'b0);
    probe("R8 record 2 kept", 7'd22, 0, 1'b1);
    alloc(7'd40, 16'h2010);
    alloc(7'd42, 16'h2018);
    probe("R8 hit does not rotate", 7'd22, 0, 1'b0);
    probe("R8 record 3 kept", 7'd23, 0, 1'b1);

    // Sweep against the reference table (R2 R4 R5 R6 R7 R8 R9 R10)
    do_reset();
    for (int k = 0; k < 4000; k++) begin
      logic av, sv, cv, cc;
      av = ($urandom % 2) == 0;
      sv = ($urandom % 4) == 0;
      cv = ($urandom % 4) != 0;
      cc = ($urandom % 4) == 0;
      step(av, TW'($urandom % 24), AW'($urandom % 64), sv, AW'($urandom % 64),
           cv, TW'($urandom % 24), cc);
      chk("R2 sweep rsp_vld", chk_rsp_vld, cv);
      chk("R10 sweep pass", chk_pass, m_exp);
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule